// File: doc/BRIEF.md
# I2C Register-Port Target with Auto-Increment

This block is an I2C target that gives a host processor access to a small bank of 8-bit control registers. SCL and SDA are oversampled by the system clock after a two-flop synchronizer. SDA is open-drain, so the block only ever pulls it low, through the registered output `sda_oe`. The 7-bit device address is a fixed 5-bit prefix followed by two strap inputs, which lets up to four targets share one bus.

After a write-addressed start, the first byte the host sends is a pointer byte. Bit 7 of the pointer byte turns auto-increment on. Bits 6..0 select a register. Any further bytes in that transaction are written starting at the pointer. A host can also set the pointer and then read, either with a repeated start or with a stop followed by a new start. Reads return the register at the pointer. They keep going for as long as the host acknowledges each byte.

Writable registers appear in parallel on `regs_o` for the surrounding logic to use. Read-only registers are fed from `ro_data`.

Top module: `i2c_regport`

## Requirements
- R1: While `rst` is high and in the cycle after it, `sda_oe` is low and every writable register reads 0.
- R2: The target pulls SDA low during the acknowledge bit only for the address 1001 0 followed by `strap[1:0]`, with bit 0 of the address byte meaning read when 1. For any other address it does not acknowledge, and it leaves SDA released and all registers unchanged until the next start.
- R3: The first byte after a matching write address is acknowledged and taken as the pointer. Bit 7 of that byte is the auto-increment flag and bits 6..0 are the register address.
- R4: Each data byte that follows the pointer is acknowledged and stored in the register at the pointer, MSB first. A register changes only through such a write.
- R5: When the auto-increment flag is set, the pointer advances by one (modulo 128) after every data byte, whether written or read. When the flag is clear, the pointer stays fixed, so repeated bytes write and read the same register.
- R6: A stop right after the pointer byte changes no register but keeps the new pointer, so the following read returns the selected register.
- R7: A read sends the register at the pointer MSB first, starting after either a repeated start or a stop then start. The target sends another byte after each host ACK. After a host NACK it releases SDA and drives nothing more.
- R8: Addresses 8 and 9 are read-only and return `ro_data[7:0]` and `ro_data[15:8]`. Writes to them are acknowledged but change nothing. Addresses 10 and above read as 0.
- R9: `sda_oe` only rises while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap | input | 2 | Low two bits of the device address |
| ro_data | input | 16 | Contents of read-only registers 8 (low byte) and 9 |
| regs_o | output | 64 | Writable registers 0..7, register n at bits 8n+7..8n |

## Verification
On every cycle, the assertions check the reset value of `sda_oe`, that SDA is only ever pulled low while SCL is low, that an idle target never drives the line, that registers change only after an internal write strobe, and that strobes aimed at read-only addresses leave the bank untouched. Some behaviours need whole bus transactions driven by the scenarios and compared against a bench-side register model. These are address matching against the straps, how the pointer byte is split into flag and address, pointer advance with and without auto-increment, the kept pointer after an early stop, both read entry paths, and release after a NACK.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } rp_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // [0],[1] form the synchronizer, [2] holds the previous synchronized value
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign sda_s     = sda_q[1];
  assign scl_rise  = scl_q[1] & ~scl_q[2];
  assign scl_fall  = ~scl_q[1] & scl_q[2];
  assign start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
  parameter int DATA_W = 8,
  parameter int NUM_RW = 8,
  parameter int NUM_RO = 2,
  parameter int ADDR_W = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [NUM_RO*DATA_W-1:0] ro_data,
  output logic [DATA_W-1:0]        rd_data,
  output logic [NUM_RW*DATA_W-1:0] regs_o
);
  logic [DATA_W-1:0] bank [NUM_RW];

  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    always_ff @(posedge clk) begin
      if (rst) bank[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g)) bank[g] <= wr_data;
    end
    assign regs_o[g*DATA_W +: DATA_W] = bank[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_RW; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = bank[i];
    for (int j = 0; j < NUM_RO; j++)
      if (rd_addr == ADDR_W'(NUM_RW + j)) rd_data = ro_data[j*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter int         NUM_RW     = 8,
  parameter int         NUM_RO     = 2,
  parameter logic [4:0] DEV_PREFIX = 5'b10010
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe,
  input  logic [1:0]           strap,
  input  logic [NUM_RO*8-1:0]  ro_data,
  output logic [NUM_RW*8-1:0]  regs_o
);
  localparam int BYTE_W = 8;
  localparam int PTR_W  = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  rp_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q, wr_data;
  logic [PTR_W-1:0]  ptr_q, wr_addr;
  logic              ainc_q, rw_q, nack_q, wr_en;
  logic [BYTE_W-1:0] rd_data;

  i2c_regbank #(.DATA_W(BYTE_W), .NUM_RW(NUM_RW), .NUM_RO(NUM_RO), .ADDR_W(PTR_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr_q), .ro_data(ro_data), .rd_data(rd_data), .regs_o(regs_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      ainc_q  <= 1'b0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state_q <= ST_IDLE;
        sda_oe  <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise && cnt_q != LAST_BIT) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == LAST_BIT) begin
              if (state_q == ST_ADDR) begin
                if (rx_q[7:3] == DEV_PREFIX && rx_q[2:1] == strap) begin
                  sda_oe  <= 1'b1;
                  rw_q    <= rx_q[0];
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (state_q == ST_PTR) begin
                sda_oe  <= 1'b1;
                ptr_q   <= rx_q[PTR_W-1:0];
                ainc_q  <= rx_q[BYTE_W-1];
                state_q <= ST_PTR_ACK;
              end else begin
                sda_oe  <= 1'b1;
                wr_en   <= 1'b1;
                wr_addr <= ptr_q;
                wr_data <= rx_q;
                if (ainc_q) ptr_q <= ptr_q + 1'b1;
                state_q <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q    <= rd_data;
              sda_oe  <= ~rd_data[BYTE_W-1];
              state_q <= ST_RDATA;
            end else begin
              sda_oe  <= 1'b0;
              state_q <= ST_PTR;
            end
          end
          ST_PTR_ACK, ST_WDATA_ACK: if (scl_fall) begin
            sda_oe  <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_WDATA;
          end
          ST_RDATA: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == LAST_BIT) begin
                sda_oe  <= 1'b0;
                if (ainc_q) ptr_q <= ptr_q + 1'b1;
                state_q <= ST_RACK;
              end else begin
                tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx_q[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              if (!nack_q) begin
                tx_q    <= rd_data;
                sda_oe  <= ~rd_data[BYTE_W-1];
                cnt_q   <= '0;
                state_q <= ST_RDATA;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk
  import i2c_regport_pkg::*;
#(
  parameter int NUM_RW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [NUM_RW*8-1:0] regs_o,
  input logic              wr_en,
  input logic [6:0]        wr_addr,
  input rp_state_e         state_q
);
  assert_reset_release_R1: assert property (@(posedge clk) rst |=> !sda_oe);

  assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  assert_idle_released_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |=> (!sda_oe || $past(state_q) != ST_IDLE));

  assert_change_needs_write_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(regs_o) |-> $past(wr_en));

  assert_readonly_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_addr) >= NUM_RW) |=> $stable(regs_o));
endmodule

bind i2c_regport i2c_regport_chk #(.NUM_RW(NUM_RW)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe), .regs_o(regs_o),
  .wr_en(wr_en), .wr_addr(wr_addr), .state_q(state_q)
);

// File: tb/tb_i2c_regport.sv
module tb_i2c_regport;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [1:0]  STRAP = 2'b01;
  localparam logic [7:0]  WADDR = {5'b10010, STRAP, 1'b0};
  localparam logic [7:0]  RADDR = {5'b10010, STRAP, 1'b1};
  localparam logic [15:0] RO_VAL = 16'hA55A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [63:0] regs_o;
  logic sda;
  assign sda = sda_m & ~sda_oe;

  int checks = 0, fails = 0;
  logic [7:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regport dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .strap(STRAP), .ro_data(RO_VAL), .regs_o(regs_o)
  );

  function automatic logic [7:0] exp_rd(input int a);
    if (a < 8) return model[a];
    if (a == 8) return RO_VAL[7:0];
    if (a == 9) return RO_VAL[15:8];
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq(Q); scl = 1'b1; waitq(Q); sda_m = 1'b0; waitq(Q); scl = 1'b0; waitq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq(Q); scl = 1'b1; waitq(Q); sda_m = 1'b1; waitq(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; waitq(Q); scl = 1'b1; waitq(2*Q); scl = 1'b0; waitq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; waitq(Q); scl = 1'b1; waitq(Q); ack = sda; waitq(Q); scl = 1'b0; waitq(Q);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      waitq(Q); scl = 1'b1; waitq(Q); b = {b[6:0], sda}; waitq(Q); scl = 1'b0;
    end
    waitq(Q);
    put_bit(nack);
  endtask

  // Pointer write, optional data, then stop
  task automatic write_txn(input logic [7:0] p, input int n, input logic [7:0] d [4], input string req);
    logic ack;
    int a;
    bus_start();
    send_byte(WADDR, ack); chk(ack == 1'b0, "R2 address ack", ack, 0);
    send_byte(p, ack);     chk(ack == 1'b0, "R3 pointer ack", ack, 0);
    a = int'(p[6:0]);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ack); chk(ack == 1'b0, req, ack, 0);
      if (a < 8) model[a] = d[i];
      if (p[7]) a = (a + 1) % 128;
    end
    bus_stop();
  endtask

  // Set pointer then read n bytes, via repeated start or stop+start
  task automatic read_txn(input logic [7:0] p, input int n, input bit restart, input string req);
    logic ack;
    logic [7:0] b;
    int a;
    bus_start();
    send_byte(WADDR, ack);
    send_byte(p, ack);
    if (!restart) bus_stop();
    bus_start();
    send_byte(RADDR, ack); chk(ack == 1'b0, "R7 read address ack", ack, 0);
    a = int'(p[6:0]);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, b);
      chk(b == exp_rd(a), req, b, exp_rd(a));
      if (p[7]) a = (a + 1) % 128;
    end
    waitq(2);
    chk(sda_oe == 1'b0, "R7 release after NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic chk_regs(input string req);
    logic [63:0] e;
    for (int i = 0; i < 8; i++) e[i*8 +: 8] = model[i];
    chk(regs_o == e, req, regs_o, e);
  endtask

  initial begin
    repeat (1800000 / CLK_PERIOD) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d [4];
    logic ack;
    logic [7:0] b;
    int seed;
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    seed = 1234;
    void'($urandom(seed));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    waitq(2);
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    chk(regs_o == 64'h0, "R1 registers after reset", regs_o, 0);

    // Auto-increment write burst at 2..4, read back with repeated start
    d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33; d[3] = 8'h00;
    write_txn(8'h82, 3, d, "R4 data ack");
    chk_regs("R4 burst stored");
    read_txn(8'h82, 3, 1'b1, "R5 auto-inc read");

    // No auto-increment: both bytes hit register 5
    d[0] = 8'h44; d[1] = 8'h55;
    write_txn(8'h05, 2, d, "R4 data ack");
    chk_regs("R5 fixed pointer write");
    read_txn(8'h05, 2, 1'b0, "R5 fixed pointer read stop-start");

    // Stop right after the pointer byte, then plain read
    write_txn(8'h83, 0, d, "R6");
    chk_regs("R6 no register changed");
    bus_start();
    send_byte(RADDR, ack);
    recv_byte(1'b1, b);
    chk(b == model[3], "R6 read after stop", b, model[3]);
    bus_stop();

    // Read-only and unmapped addresses
    d[0] = 8'h77; d[1] = 8'h66;
    write_txn(8'h88, 2, d, "R8 read-only write ack");
    chk_regs("R8 bank unchanged");
    read_txn(8'h88, 3, 1'b1, "R8 read-only and unmapped values");

    // Wrong strap: no ack, rest ignored
    bus_start();
    send_byte({5'b10010, ~STRAP, 1'b0}, ack); chk(ack == 1'b1, "R2 mismatched address nack", ack, 1);
    send_byte(8'h80, ack); chk(ack == 1'b1, "R2 ignored byte", ack, 1);
    send_byte(8'hFF, ack); chk(ack == 1'b1, "R2 ignored byte", ack, 1);
    bus_stop();
    chk_regs("R2 bank unchanged after mismatch");
    bus_start();
    send_byte({5'b10110, STRAP, 1'b0}, ack); chk(ack == 1'b1, "R2 prefix mismatch nack", ack, 1);
    bus_stop();

    // Pointer field split: bit 7 flag with address 7 at the top of the bank
    d[0] = 8'hC3; d[1] = 8'h3C;
    write_txn(8'h87, 2, d, "R3 data ack");
    read_txn(8'h87, 3, 1'b1, "R3 wrap into read-only");

    // Constrained random transactions
    for (int t = 0; t < 25; t++) begin
      int n;
      logic [7:0] p;
      n = 1 + ($urandom % 4);
      p = {1'($urandom % 2), 7'($urandom % 12)};
      for (int i = 0; i < 4; i++) d[i] = 8'($urandom);
      write_txn(p, n, d, "R4 random write ack");
      read_txn(p, n, 1'($urandom % 2), "R7 random read");
    end
    chk_regs("R4 final bank");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule